// File: doc/BRIEF.md
# Dual Latched Bus Register with Function Select

The block keeps two independent data words, channel A and channel B, each in its own hold register with private load, clear and disable controls. A hold register captures its data source on every rising clock edge where its strobe is high and keeps the word unchanged while the strobe is low, which is the clocked form of a transparent latch that freezes when its strobe drops. A channel clear empties the word whatever the strobe does, and a channel disable turns its driver off without touching the stored word.

Each channel's driver is expressed as a word plus an enable flag instead of a real three-state pad. A 2-bit function select then resolves the two drivers onto one shared output bus: nothing, channel A, channel B, or the bitwise OR of both. A disabled channel adds nothing to the bus.

Each channel can alternatively be loaded from its own serial-in shift register. Both shift registers share one serial data input and one shift enable, so a word can be assembled bit by bit and then moved into either store.

Top module: `dual_bus_register`

## Requirements
- R1: At a rising clock edge with `rst_n` low, both stored words and both shift registers become zero, so all outputs read zero afterwards while drivers stay enabled unless disabled.
- R2: At a rising edge with a channel's strobe high and its clear low, the stored word takes the selected data source; the new word appears on that channel's output after that edge.
- R3: At a rising edge with a channel's strobe low and its clear low, the stored word is kept and any change of the data input is ignored.
- R4: At a rising edge with a channel's clear high, the stored word becomes zero whether its strobe is high or low.
- R5: While a channel's disable is high, its enable output is 0 and its word output is zero; the stored word is neither lost nor changed by the disable and reappears when disable returns low.
- R6: The two channels share no control: strobe, clear, disable and source select of one channel have no effect on the other channel's stored word or outputs.
- R7: The bus follows the select code: 00 gives all zeros, 01 gives channel A's driven word, 10 gives channel B's driven word, 11 gives the bitwise OR of both driven words; a disabled channel contributes zero.
- R8: At a rising edge with `shift_en` high, each shift register moves one place toward its most significant bit and `ser_in` enters bit 0; with `shift_en` low it holds.
- R9: A channel's source select chooses the data source its store loads: 0 takes the parallel data input, 1 takes that channel's shift register word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_in | input | 1 | Serial data shared by both shift registers |
| shift_en | input | 1 | Shift enable shared by both shift registers |
| sel | input | 2 | Bus function select (00 none, 01 A, 10 B, 11 A OR B) |
| a_data | input | WIDTH | Channel A parallel data |
| a_stb | input | 1 | Channel A load strobe, active high |
| a_clr | input | 1 | Channel A clear, active high |
| a_dis | input | 1 | Channel A driver disable, active high |
| a_src_ser | input | 1 | Channel A source: 0 parallel, 1 shift register |
| b_data | input | WIDTH | Channel B parallel data |
| b_stb | input | 1 | Channel B load strobe, active high |
| b_clr | input | 1 | Channel B clear, active high |
| b_dis | input | 1 | Channel B driver disable, active high |
| b_src_ser | input | 1 | Channel B source: 0 parallel, 1 shift register |
| a_q | output | WIDTH | Channel A driven word (zero when disabled) |
| a_oe | output | 1 | Channel A driver enable |
| b_q | output | WIDTH | Channel B driven word (zero when disabled) |
| b_oe | output | 1 | Channel B driver enable |
| bus | output | WIDTH | Resolved shared bus |

## Verification
The bench builds the block with WIDTH at 4, so every one of the 16 data values per channel and every pairing of the two words under the OR code is reachable by random stimulus in a few thousand cycles. At that width a shift register is filled with a fresh word in four clocks, which lets directed sequences walk a known pattern through the serial path and move it into either store within a short window. Clear coinciding with a high strobe, disable over a stored word, and loads on one channel while the other holds are driven both directedly and at random.

// File: rtl/dlbr_pkg.sv
// Shared definitions for the dual latched bus register.
// Assumes: the select code values are decoded only by dlbr_bus_mux.
package dlbr_pkg;

    // Bus function select codes.
    typedef enum logic [1:0] {
        BUS_NONE = 2'b00,
        BUS_A    = 2'b01,
        BUS_B    = 2'b10,
        BUS_OR   = 2'b11
    } bus_sel_e;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/dlbr_shifter.sv
// Serial-in shift register feeding one channel store.
// Shifts toward the MSB; serial data enters bit 0.
// Assumes: synchronous active-low reset, WIDTH >= 2.
module dlbr_shifter #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic [WIDTH-1:0] word
);

    logic [WIDTH-1:0] sreg;

    // Shift one place per enabled clock, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sreg <= '0;
        else if (shift_en)
            sreg <= {sreg[WIDTH-2:0], ser_in};
    end

    assign word = sreg;

    // R8
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (sreg[0] == $past(ser_in)) &&
                     (sreg[WIDTH-1:1] == $past(sreg[WIDTH-2:0])));

    // R8
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sreg));

endmodule

// File: rtl/dlbr_hold.sv
// Clocked hold register for one channel with its driver model.
// Strobe acts as a load enable; clear has priority over load;
// disable gates the driver only and never alters the stored word.
// Assumes: synchronous active-low reset; clr/stb/dis active high.
module dlbr_hold #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic             clr,
    input  logic             dis,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q_val,
    output logic             q_en
);

    logic [WIDTH-1:0] store;

    // Capture the data source while strobe is high; clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            store <= '0;
        else if (stb)
            store <= din;
    end

    // Driver model: disabled driver reports zero and enable low.
    always_comb begin
        q_en  = !dis;
        q_val = dis ? '0 : store;
    end

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !clr) |=> (store == $past(din)));

    // R3
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stb && !clr) |=> $stable(store));

    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (store == '0));

endmodule

// File: rtl/dlbr_bus_mux.sv
// Resolves the two channel drivers onto the shared bus.
// Assumes: a disabled driver already presents a zero word, but the
// enable is still applied so the bus never depends on that.
module dlbr_bus_mux
    import dlbr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  bus_sel_e         sel,
    input  logic [WIDTH-1:0] a_val,
    input  logic             a_en,
    input  logic [WIDTH-1:0] b_val,
    input  logic             b_en,
    output logic [WIDTH-1:0] bus
);

    logic [WIDTH-1:0] a_drv;
    logic [WIDTH-1:0] b_drv;

    // Mask each channel by its enable, then apply the function select.
    always_comb begin
        a_drv = a_en ? a_val : '0;
        b_drv = b_en ? b_val : '0;
        unique case (sel)
            BUS_NONE: bus = '0;
            BUS_A:    bus = a_drv;
            BUS_B:    bus = b_drv;
            BUS_OR:   bus = a_drv | b_drv;
            default:  bus = '0;
        endcase
    end

endmodule

// File: rtl/dual_bus_register.sv
// Top of the dual latched bus register: two channel stores, each fed
// from a parallel input or its own serial shift register, resolved
// onto one shared bus by a 2-bit function select.
// Assumes: one clock domain; synchronous active-low reset.
module dual_bus_register
    import dlbr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic             shift_en,
    input  logic [1:0]       sel,
    input  logic [WIDTH-1:0] a_data,
    input  logic             a_stb,
    input  logic             a_clr,
    input  logic             a_dis,
    input  logic             a_src_ser,
    input  logic [WIDTH-1:0] b_data,
    input  logic             b_stb,
    input  logic             b_clr,
    input  logic             b_dis,
    input  logic             b_src_ser,
    output logic [WIDTH-1:0] a_q,
    output logic             a_oe,
    output logic [WIDTH-1:0] b_q,
    output logic             b_oe,
    output logic [WIDTH-1:0] bus
);

    logic [NUM_CH-1:0][WIDTH-1:0] ch_data;
    logic [NUM_CH-1:0]            ch_stb;
    logic [NUM_CH-1:0]            ch_clr;
    logic [NUM_CH-1:0]            ch_dis;
    logic [NUM_CH-1:0]            ch_src;
    logic [NUM_CH-1:0][WIDTH-1:0] ch_q;
    logic [NUM_CH-1:0]            ch_en;
    bus_sel_e                     sel_e;

    // Gather per-channel controls into arrays for the generate loop.
    always_comb begin
        ch_data = {b_data, a_data};
        ch_stb  = {b_stb, a_stb};
        ch_clr  = {b_clr, a_clr};
        ch_dis  = {b_dis, a_dis};
        ch_src  = {b_src_ser, a_src_ser};
        sel_e   = bus_sel_e'(sel);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [WIDTH-1:0] sh_word;
        logic [WIDTH-1:0] src_word;

        dlbr_shifter #(.WIDTH(WIDTH)) u_shift (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .ser_in   (ser_in),
            .word     (sh_word)
        );

        // Pick the load source for this channel.
        assign src_word = ch_src[c] ? sh_word : ch_data[c];

        dlbr_hold #(.WIDTH(WIDTH)) u_hold (
            .clk   (clk),
            .rst_n (rst_n),
            .stb   (ch_stb[c]),
            .clr   (ch_clr[c]),
            .dis   (ch_dis[c]),
            .din   (src_word),
            .q_val (ch_q[c]),
            .q_en  (ch_en[c])
        );
    end

    dlbr_bus_mux #(.WIDTH(WIDTH)) u_mux (
        .sel   (sel_e),
        .a_val (ch_q[0]),
        .a_en  (ch_en[0]),
        .b_val (ch_q[1]),
        .b_en  (ch_en[1]),
        .bus   (bus)
    );

    assign a_q  = ch_q[0];
    assign a_oe = ch_en[0];
    assign b_q  = ch_q[1];
    assign b_oe = ch_en[1];

    // R5
    a_dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_dis |-> (!a_oe && a_q == '0));

    // R5
    b_dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_dis |-> (!b_oe && b_q == '0));

    // R7
    bus_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00) |-> (bus == '0));

    // R7
    bus_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b11) |-> (bus == (a_q | b_q)));

    // R1
    reset_empty_chk: assert property (@(posedge clk)
        !rst_n |=> (g_ch[0].u_hold.q_val == '0 && b_q == '0));

endmodule

// File: tb/dual_bus_register_tb.sv
module dual_bus_register_tb;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ser_in, shift_en;
    logic [1:0]   sel;
    logic [W-1:0] a_data, b_data;
    logic         a_stb, a_clr, a_dis, a_src;
    logic         b_stb, b_clr, b_dis, b_src;
    logic [W-1:0] a_q, b_q, bus;
    logic         a_oe, b_oe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [W-1:0] m_sa, m_sb, m_sh;

    always #2 clk = ~clk;

    dual_bus_register #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_en(shift_en),
        .sel(sel),
        .a_data(a_data), .a_stb(a_stb), .a_clr(a_clr), .a_dis(a_dis),
        .a_src_ser(a_src),
        .b_data(b_data), .b_stb(b_stb), .b_clr(b_clr), .b_dis(b_dis),
        .b_src_ser(b_src),
        .a_q(a_q), .a_oe(a_oe), .b_q(b_q), .b_oe(b_oe), .bus(bus)
    );

    function automatic logic [W-1:0] drv(input logic [W-1:0] s, input logic d);
        return d ? '0 : s;
    endfunction

    function automatic logic [W-1:0] exp_bus(input logic [1:0] s,
            input logic [W-1:0] av, input logic [W-1:0] bv);
        case (s)
            2'b00: return '0;
            2'b01: return av;
            2'b10: return bv;
            default: return av | bv;
        endcase
    endfunction

    function automatic logic [W-1:0] nxt_store(input logic [W-1:0] cur,
            input logic stb, input logic clr, input logic src,
            input logic [W-1:0] d, input logic [W-1:0] sh);
        if (!rst_n || clr) return '0;
        if (stb) return src ? sh : d;
        return cur;
    endfunction

    // Check outputs for the current inputs, then advance the model one edge.
    task automatic step(input string tag);
        logic [W-1:0] ea, eb, ebus;
        logic [W-1:0] na, nb, nsh;
        @(negedge clk);
        #1;
        ea = drv(m_sa, a_dis);
        eb = drv(m_sb, b_dis);
        ebus = exp_bus(sel, ea, eb);
        checks++;
        if (a_q !== ea || b_q !== eb || a_oe !== !a_dis || b_oe !== !b_dis
                || bus !== ebus) begin
            errors++;
            $display("FAIL %s: a_q=%h a_oe=%b b_q=%h b_oe=%b bus=%h expected a_q=%h a_oe=%b b_q=%h b_oe=%b bus=%h",
                tag, a_q, a_oe, b_q, b_oe, bus, ea, !a_dis, eb, !b_dis, ebus);
        end
        na  = nxt_store(m_sa, a_stb, a_clr, a_src, a_data, m_sh);
        nb  = nxt_store(m_sb, b_stb, b_clr, b_src, b_data, m_sh);
        nsh = !rst_n ? '0 : (shift_en ? {m_sh[W-2:0], ser_in} : m_sh);
        @(posedge clk);
        m_sa = na; m_sb = nb; m_sh = nsh;
        #0.5;
    endtask

    task automatic idle();
        rst_n = 1'b1; ser_in = 0; shift_en = 0; sel = 2'b11;
        a_data = '0; a_stb = 0; a_clr = 0; a_dis = 0; a_src = 0;
        b_data = '0; b_stb = 0; b_clr = 0; b_dis = 0; b_src = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd4242));
        m_sa = 'x; m_sb = 'x; m_sh = 'x;
        idle();
        rst_n = 1'b0;
        @(posedge clk); #0.5;
        m_sa = '0; m_sb = '0; m_sh = '0;
        step("R1");              // reset held: all zero
        rst_n = 1'b1;
        step("R1");

        // R2: load both, then look at each alone
        a_data = 4'hA; a_stb = 1; b_data = 4'h5; b_stb = 1;
        step("R2");
        a_stb = 0; b_stb = 0; sel = 2'b01; step("R2");
        sel = 2'b10; step("R2");
        sel = 2'b11; step("R7");
        sel = 2'b00; step("R7");

        // R3: data changes with strobe low are ignored
        sel = 2'b11; a_data = 4'h3; b_data = 4'hC; step("R3");
        step("R3");

        // R4: clear while strobe high beats the load
        a_stb = 1; a_clr = 1; a_data = 4'hF; step("R4");
        a_stb = 0; a_clr = 0; step("R4");
        b_clr = 1; step("R4");
        b_clr = 0; step("R4");

        // R5: disable hides the word but keeps it
        a_data = 4'h9; a_stb = 1; step("R5");
        a_stb = 0; a_dis = 1; sel = 2'b01; step("R5");
        sel = 2'b11; step("R5");
        a_dis = 0; step("R5");

        // R6: activity on B leaves A untouched
        b_stb = 1; b_data = 4'h6; b_dis = 1; b_clr = 0; step("R6");
        b_clr = 1; step("R6");
        b_stb = 0; b_clr = 0; b_dis = 0; sel = 2'b01; step("R6");

        // R8/R9: shift 1011 in, move into B via the serial source
        shift_en = 1;
        for (int i = 0; i < W; i++) begin
            ser_in = (4'b1011 >> (W - 1 - i)) & 1'b1;
            step("R8");
        end
        shift_en = 0; ser_in = 1; step("R8");
        b_src = 1; b_stb = 1; b_data = 4'h0; sel = 2'b10; step("R9");
        b_stb = 0; b_src = 0; step("R9");
        a_src = 1; a_stb = 1; sel = 2'b01; step("R9");
        a_stb = 0; a_src = 0; step("R9");

        // R1: reset in mid-run empties everything
        rst_n = 0; step("R1");
        rst_n = 1; sel = 2'b11; step("R1");

        // Random phase over all select codes
        for (int n = 0; n < 3000; n++) begin
            rst_n    = ($urandom % 97) != 0;
            ser_in   = $urandom;
            shift_en = $urandom;
            sel      = $urandom;
            a_data = $urandom; a_stb = $urandom; a_clr = ($urandom % 5) == 0;
            a_dis  = ($urandom % 4) == 0; a_src = ($urandom % 3) == 0;
            b_data = $urandom; b_stb = $urandom; b_clr = ($urandom % 5) == 0;
            b_dis  = ($urandom % 4) == 0; b_src = ($urandom % 3) == 0;
            step("R7");
        end
        idle();
        step("R7");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule